// File: doc/BRIEF.md
# Tick-Paced Serial Byte Transceiver

This block is a full-duplex serial link for 8-bit characters. Each frame is one low start bit, eight data bits sent least significant first, and one high stop bit. There is no parity. Neither direction keeps its own per-bit clock counter. A single free-running pacer produces a one-cycle enable every `TICK_CLKS` system clocks. Both directions count bit periods in these enables, using a divider chosen by a small rate code.

A host starts a transmission by pulsing a request while the transmitter is neither holding a pending request nor busy. The byte is captured at that moment. The frame begins on the next enable. On the receive side, the serial input passes through two flops, and the receiver waits on the enables for the line to go low. It waits half a bit period and then samples every full bit period. When the frame ends, it presents the byte and raises a ready flag, which the host clears with a pulse.

Top module: `uart_tick_xcvr`

## Requirements
- R1: The pacer produces one enable every `TICK_CLKS` clocks, so every transmitted bit lasts exactly divider × `TICK_CLKS` clocks.
- R2: `rate_sel` picks the divider in enables: 0→24, 1→12, 2→6, 3→4, 4→2. Codes 5 to 7 fall back to 4.
- R3: `txd` rests high. A frame is start (0), then data bit 0 through bit 7, then stop (1), each held for one bit period.
- R4: A `tx_req` pulse seen while `tx_pending` and `tx_busy` are both low captures `tx_byte` and raises `tx_pending` on the next clock.
- R5: A `tx_req` arriving while `tx_pending` or `tx_busy` is high is ignored: the frame in flight is unchanged and no further frame follows.
- R6: On the first enable after `tx_pending` rises, `tx_pending` drops and `tx_busy` rises together with the start bit. `tx_busy` falls ten bit periods after the start bit begins.
- R7: The receiver synchronizes `rxd` through two flops. On an enable it sees low while idle, it samples after half the divider and then every full divider. It assembles the data least significant bit first.
- R8: At the end of a received frame, `rx_byte` and `rx_ready` are updated together. A `rx_ack` pulse clears `rx_ready` on the next clock.
- R9: A frame that completes while `rx_ready` is still high overwrites `rx_byte`, and no error indication is given.
- R10: After reset, `txd` is high, `tx_pending`, `tx_busy` and `rx_ready` are low, and `rx_byte` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | 3 | Baud rate code |
| tx_byte | input | 8 | Byte to transmit |
| tx_req | input | 1 | Transmit request pulse |
| tx_pending | output | 1 | Request accepted, frame not yet begun |
| tx_busy | output | 1 | Frame on the line |
| txd | output | 1 | Serial output, idle high |
| rxd | input | 1 | Serial input, idle high |
| rx_ack | input | 1 | Clears rx_ready |
| rx_byte | output | 8 | Last received byte |
| rx_ready | output | 1 | Received byte available |

## Verification
`tx_pending` is due one clock after a request and is read at the next falling edge. The bench finds the start bit by watching `txd` at falling edges. From that point it counts clocks and samples each bit at its centre, half a bit period plus whole periods, with the period computed from its own rate table. `tx_busy` is read at the centre of the stop bit and again two clocks after the tenth bit boundary. For the receiver, the latest completion point is half a bit plus nine bits after detection, and detection trails the start edge by at most one enable plus the synchronizer. The bench therefore reads `rx_ready` and `rx_byte` only after the frame has ended, and reads the effect of `rx_ack` one clock after the pulse.

// File: rtl/uart_tick_pkg.sv
package uart_tick_pkg;
  localparam int DIV_W     = 5;
  localparam int SEL_W     = 3;
  localparam int BYTE_W    = 8;
  localparam int FRAME_CNT = 10;
  localparam int CNT_W     = $clog2(FRAME_CNT + 1);

  typedef logic [DIV_W-1:0]  div_t;
  typedef logic [BYTE_W-1:0] byte_t;

  // rate code to bit period in pacer enables
  function automatic div_t rate_to_div(input logic [SEL_W-1:0] sel);
    case (sel)
      3'd0:    rate_to_div = div_t'(24);
      3'd1:    rate_to_div = div_t'(12);
      3'd2:    rate_to_div = div_t'(6);
      3'd3:    rate_to_div = div_t'(4);
      3'd4:    rate_to_div = div_t'(2);
      default: rate_to_div = div_t'(4);
    endcase
  endfunction
endpackage

// File: rtl/uart_tick_gen.sv
module uart_tick_gen #(
  parameter int TICK_CLKS = 217
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int W = (TICK_CLKS > 1) ? $clog2(TICK_CLKS) : 1;

  logic [W-1:0] cnt_q, cnt_d;

  assign tick = (cnt_q == W'(TICK_CLKS - 1));

  always_comb begin
    cnt_d = tick ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/uart_tick_tx.sv
module uart_tick_tx
  import uart_tick_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  div_t  div_full,
  input  logic  req,
  input  byte_t req_byte,
  output logic  pending,
  output logic  busy,
  output logic  txd
);
  logic             pend_q, pend_d, busy_q, busy_d, txd_q, txd_d;
  byte_t            hold_q, hold_d, sh_q, sh_d;
  div_t             div_q, div_d;
  logic [CNT_W-1:0] bit_q, bit_d;

  always_comb begin
    pend_d = pend_q;
    busy_d = busy_q;
    txd_d  = txd_q;
    hold_d = hold_q;
    sh_d   = sh_q;
    div_d  = div_q;
    bit_d  = bit_q;
    if (req && !pend_q && !busy_q) begin
      pend_d = 1'b1;
      hold_d = req_byte;
    end
    if (tick) begin
      if (busy_q) begin
        if (div_q == div_t'(1)) begin
          txd_d = sh_q[0];
          sh_d  = {1'b1, sh_q[BYTE_W-1:1]};
          div_d = div_full;
          bit_d = bit_q - CNT_W'(1);
          if (bit_q == CNT_W'(1)) busy_d = 1'b0;
        end else begin
          div_d = div_q - div_t'(1);
        end
      end else if (pend_q) begin
        sh_d   = hold_q;
        txd_d  = 1'b0;
        div_d  = div_full;
        bit_d  = CNT_W'(FRAME_CNT);
        pend_d = 1'b0;
        busy_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
      hold_q <= '0;
      sh_q   <= '1;
      div_q  <= '0;
      bit_q  <= '0;
    end else begin
      pend_q <= pend_d;
      busy_q <= busy_d;
      txd_q  <= txd_d;
      hold_q <= hold_d;
      sh_q   <= sh_d;
      div_q  <= div_d;
      bit_q  <= bit_d;
    end
  end

  assign pending = pend_q;
  assign busy    = busy_q;
  assign txd     = txd_q;
endmodule

// File: rtl/uart_tick_rx.sv
module uart_tick_rx
  import uart_tick_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  tick,
  input  div_t  div_full,
  input  logic  rxd,
  input  logic  ack,
  output byte_t data,
  output logic  ready
);
  logic             s1_q, s2_q;
  logic             act_q, act_d, rdy_q, rdy_d;
  byte_t            sh_q, sh_d, dat_q, dat_d;
  div_t             div_q, div_d;
  logic [CNT_W-1:0] bit_q, bit_d;

  always_comb begin
    act_d = act_q;
    rdy_d = rdy_q;
    sh_d  = sh_q;
    dat_d = dat_q;
    div_d = div_q;
    bit_d = bit_q;
    if (ack) rdy_d = 1'b0;
    if (tick) begin
      if (act_q) begin
        if (div_q == div_t'(1)) begin
          bit_d = bit_q - CNT_W'(1);
          if (bit_q == CNT_W'(1)) begin
            dat_d = sh_q;
            act_d = 1'b0;
            rdy_d = 1'b1;
          end else begin
            sh_d  = {s2_q, sh_q[BYTE_W-1:1]};
            div_d = div_full;
          end
        end else begin
          div_d = div_q - div_t'(1);
        end
      end else if (!s2_q) begin
        div_d = div_full >> 1;
        bit_d = CNT_W'(FRAME_CNT);
        act_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b1;
      s2_q  <= 1'b1;
      act_q <= 1'b0;
      rdy_q <= 1'b0;
      sh_q  <= '0;
      dat_q <= '0;
      div_q <= '0;
      bit_q <= '0;
    end else begin
      s1_q  <= rxd;
      s2_q  <= s1_q;
      act_q <= act_d;
      rdy_q <= rdy_d;
      sh_q  <= sh_d;
      dat_q <= dat_d;
      div_q <= div_d;
      bit_q <= bit_d;
    end
  end

  assign data  = dat_q;
  assign ready = rdy_q;
endmodule

// File: rtl/uart_tick_xcvr.sv
module uart_tick_xcvr
  import uart_tick_pkg::*;
#(
  parameter int TICK_CLKS = 217
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic [7:0]       tx_byte,
  input  logic             tx_req,
  output logic             tx_pending,
  output logic             tx_busy,
  output logic             txd,
  input  logic             rxd,
  input  logic             rx_ack,
  output logic [7:0]       rx_byte,
  output logic             rx_ready
);
  logic tick;
  div_t div_full;

  assign div_full = rate_to_div(rate_sel);

  uart_tick_gen #(.TICK_CLKS(TICK_CLKS)) u_gen (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  uart_tick_tx u_tx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .div_full(div_full),
    .req(tx_req), .req_byte(tx_byte),
    .pending(tx_pending), .busy(tx_busy), .txd(txd)
  );

  uart_tick_rx u_rx (
    .clk(clk), .rst_n(rst_n), .tick(tick), .div_full(div_full),
    .rxd(rxd), .ack(rx_ack), .data(rx_byte), .ready(rx_ready)
  );
endmodule

// File: rtl/uart_tick_xcvr_chk.sv
module uart_tick_xcvr_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       txd,
  input logic       tx_pending,
  input logic       tx_busy,
  input logic [7:0] rx_byte,
  input logic       rx_ready,
  input logic       rx_ack
);
  p_idle_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_busy |-> txd);

  p_txd_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> (tx_busy || $past(tx_busy)));

  p_start_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_busy) |-> !txd);

  p_phase_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_pending && tx_busy));

  p_pend_to_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_pending) |-> tx_busy);

  p_byte_with_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rx_byte) |-> rx_ready);

  p_ready_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_ready) |-> $past(rx_ack));
endmodule

bind uart_tick_xcvr uart_tick_xcvr_chk u_chk (
  .clk(clk), .rst_n(rst_n), .txd(txd), .tx_pending(tx_pending),
  .tx_busy(tx_busy), .rx_byte(rx_byte), .rx_ready(rx_ready), .rx_ack(rx_ack)
);

// File: tb/sim_uart_tick_xcvr.sv
module sim_uart_tick_xcvr;
  localparam int CLK_PERIOD = 10;
  localparam int TICK       = 8;
  localparam int WATCHDOG   = 150000;
  localparam int NVEC       = 6;
  // {rate code, byte}
  localparam logic [10:0] VEC [NVEC] = '{
    {3'd0, 8'h5A}, {3'd1, 8'h81}, {3'd2, 8'h00},
    {3'd3, 8'hFF}, {3'd4, 8'hC3}, {3'd6, 8'h96}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] rate_sel;
  logic [7:0] tx_byte;
  logic       tx_req, tx_pending, tx_busy, txd;
  logic       rx_ack, rx_ready, loop, drv_rxd, rxd;
  logic [7:0] rx_byte;
  int n_run = 0;
  int n_bad = 0;

  assign rxd = loop ? txd : drv_rxd;
  always #(CLK_PERIOD/2) clk = ~clk;

  uart_tick_xcvr #(.TICK_CLKS(TICK)) u0 (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel), .tx_byte(tx_byte),
    .tx_req(tx_req), .tx_pending(tx_pending), .tx_busy(tx_busy), .txd(txd),
    .rxd(rxd), .rx_ack(rx_ack), .rx_byte(rx_byte), .rx_ready(rx_ready)
  );

  function automatic int exp_div(input logic [2:0] s);
    case (s)
      3'd0: return 24; 3'd1: return 12; 3'd2: return 6;
      3'd3: return 4;  3'd4: return 2;  default: return 4;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk); tx_byte = d; tx_req = 1'b1;
    @(negedge clk); tx_req = 1'b0;
  endtask

  task automatic cap_frame(input int b, output logic [9:0] fr, output logic busy_mid);
    int guard = 0;
    while (txd !== 1'b0 && guard < 20000) begin @(negedge clk); guard++; end
    repeat (b/2) @(negedge clk);
    fr[0] = txd;
    for (int k = 1; k < 10; k++) begin
      repeat (b) @(negedge clk);
      fr[k] = txd;
    end
    busy_mid = tx_busy;
  endtask

  task automatic drive_rx(input logic [7:0] d, input int b);
    logic [9:0] fr = {1'b1, d, 1'b0};
    for (int k = 0; k < 10; k++) begin
      @(negedge clk); drv_rxd = fr[k];
      repeat (b-1) @(negedge clk);
    end
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    n_run++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end

  initial begin
    logic [9:0] fr;
    logic       bm;
    int         b;
    rst_n = 1'b0; rate_sel = 3'd3; tx_byte = '0; tx_req = 1'b0;
    rx_ack = 1'b0; loop = 1'b1; drv_rxd = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(txd === 1'b1 && tx_pending === 1'b0 && tx_busy === 1'b0 && rx_ready === 1'b0,
        "R10 flags", {12'd0, txd, tx_pending, tx_busy, rx_ready}, 16'h8);
    chk(rx_byte === 8'h00, "R10 rx_byte", {8'd0, rx_byte}, 16'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // vector table: R1 R2 R3 R6 R7 R8 through loopback
    for (int v = 0; v < NVEC; v++) begin
      rate_sel = VEC[v][10:8];
      b = exp_div(VEC[v][10:8]) * TICK;
      send(VEC[v][7:0]);
      chk(tx_pending === 1'b1, "R4 pending", {15'd0, tx_pending}, 16'h1);
      cap_frame(b, fr, bm);
      chk(fr === {1'b1, VEC[v][7:0], 1'b0}, "R1 R2 R3 frame", {6'd0, fr}, {6'd0, 1'b1, VEC[v][7:0], 1'b0});
      chk(bm === 1'b1, "R6 busy mid stop", {15'd0, bm}, 16'h1);
      repeat (b/2 + 2) @(negedge clk);
      chk(tx_busy === 1'b0, "R6 busy end", {15'd0, tx_busy}, 16'h0);
      chk(rx_ready === 1'b1 && rx_byte === VEC[v][7:0], "R7 R8 rx byte",
          {7'd0, rx_ready, rx_byte}, {7'd0, 1'b1, VEC[v][7:0]});
      @(negedge clk); rx_ack = 1'b1;
      @(negedge clk); rx_ack = 1'b0;
      chk(rx_ready === 1'b0, "R8 ack clears", {15'd0, rx_ready}, 16'h0);
    end

    // R4 R5: requests while pending and while busy are ignored
    rate_sel = 3'd3; b = 4 * TICK;
    @(negedge clk); tx_byte = 8'hA5; tx_req = 1'b1;
    @(negedge clk); tx_byte = 8'h3C;
    @(negedge clk); tx_req = 1'b0;
    fork
      cap_frame(b, fr, bm);
      begin repeat (3 * TICK) @(negedge clk); send(8'hFF); end
    join
    chk(fr === {1'b1, 8'hA5, 1'b0}, "R5 frame kept", {6'd0, fr}, {6'd0, 1'b1, 8'hA5, 1'b0});
    repeat (b/2 + 2) @(negedge clk);
    chk(tx_pending === 1'b0, "R5 nothing pending", {15'd0, tx_pending}, 16'h0);
    begin
      bit stayed = 1'b1;
      for (int i = 0; i < 3 * b; i++) begin
        @(negedge clk);
        if (txd !== 1'b1 || tx_busy !== 1'b0) stayed = 1'b0;
      end
      chk(stayed, "R5 no extra frame", {15'd0, stayed}, 16'h1);
    end
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;

    // R7 R9: bench-driven frames, second overwrites without ack
    loop = 1'b0; rate_sel = 3'd2; b = 6 * TICK;
    repeat (b) @(negedge clk);
    drive_rx(8'h4D, b);
    repeat (TICK + 4) @(negedge clk);
    chk(rx_ready === 1'b1 && rx_byte === 8'h4D, "R7 direct rx",
        {7'd0, rx_ready, rx_byte}, {7'd0, 1'b1, 8'h4D});
    drive_rx(8'hB2, b);
    repeat (TICK + 4) @(negedge clk);
    chk(rx_ready === 1'b1 && rx_byte === 8'hB2, "R9 overwrite",
        {7'd0, rx_ready, rx_byte}, {7'd0, 1'b1, 8'hB2});
    @(negedge clk); rx_ack = 1'b1;
    @(negedge clk); rx_ack = 1'b0;
    chk(rx_ready === 1'b0 && rx_byte === 8'hB2, "R8 ack keeps byte",
        {7'd0, rx_ready, rx_byte}, {7'd0, 1'b0, 8'hB2});

    $display("  [TB] %0d tests run, %0d failed", n_run, n_bad);
    $finish;
  end
endmodule